// File: doc/BRIEF.md
# Video Sync Format Detector

The detector watches a stream of horizontal, vertical and field sync strobes and decides whether it matches one user-programmed video format. It measures the line rate as the number of reference clock cycles that span a fixed number of horizontal periods. It counts the lines between successive vertical syncs. It decides whether the stream is interlaced from the behaviour of the field strobe at each vertical sync.

A match flag is raised once the measured values agree with the programmed limits for two frames in a row. The flag drops on the first frame that fails. The measured rate, line count and interlace decision are also brought out, so that a host can read them while it works out the limits for a new format.

All three strobes are active high. The block acts on their rising edges after a two-stage register on each input.

Top module: `video_fmt_detect`

## Requirements
- R1: `rate_o` holds the count of reference clock cycles between one hsync rising edge and the edge `N_HPER` periods later (default 20), so a steady period of P cycles gives `N_HPER*P`. The value updates once per `N_HPER` periods.
- R2: The rate window is inclusive. A rate equal to `cfg_min_i` or to `cfg_max_i` passes, and a rate below the minimum or above the maximum fails.
- R3: `lines_o` holds the number of hsync rising edges seen between the two most recent vsync rising edges.
- R4: At each vsync rising edge the level of `fsync_i` is sampled. `interlaced_o` is 1 when that sample differs from the one taken at the previous vsync, and 0 when it is the same.
- R5: A frame passes only when a rate has been measured and lies in the window, `lines_o` equals `cfg_lines_i`, and `interlaced_o` equals `cfg_interlaced_i`.
- R6: `match_o` rises only after two consecutive frame evaluations pass. After a single passing evaluation it stays 0.
- R7: A failing frame evaluation, or a new rate outside the window, clears `match_o` on the next clock.
- R8: While `cfg_en_i` is 0, `match_o` is 0 from the next clock on.
- R9: If no hsync rising edge arrives for `TMO` reference cycles (default 65535), the measurement is aborted and `match_o` is cleared. Gaps shorter than that leave the match in place.
- R10: After reset, `match_o`, `rate_o`, `lines_o` and `interlaced_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync strobe |
| vsync_i | input | 1 | Vertical sync strobe |
| fsync_i | input | 1 | Field strobe level |
| cfg_en_i | input | 1 | Enables user-format detection |
| cfg_min_i | input | CW | Lowest accepted rate count |
| cfg_max_i | input | CW | Highest accepted rate count |
| cfg_lines_i | input | LW | Expected lines per frame |
| cfg_interlaced_i | input | 1 | Expected interlace state |
| match_o | output | 1 | Format matched |
| rate_o | output | CW | Measured rate count |
| lines_o | output | LW | Measured lines per frame |
| interlaced_o | output | 1 | Measured interlace state |

## Verification
The assertions take the window limits, expected line count and interlace bit to be static while a classification is in progress. Only the enable may change at any time. Under that assumption, a rising match can be tied to the rate, line count and interlace values present in the evaluating cycle. The bench changes these limits only while reset is held, and toggles the enable alone during a run. It also never places an hsync edge in the same cycle as a vsync edge, so that the expected line counts are unambiguous.

// File: rtl/fmt_det_pkg.sv
package fmt_det_pkg;
  typedef enum logic [1:0] {J_IDLE, J_HALF, J_LOCK} judge_st_e;
endpackage

// File: rtl/fmt_sync_edge.sv
module fmt_sync_edge #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] q1, q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      q1 <= in_i;
      q2 <= q1;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign lvl_o[g]  = q1[g];
    assign rise_o[g] = q1[g] & ~q2[g];
  end
endmodule

// File: rtl/fmt_hrate_meter.sv
module fmt_hrate_meter #(
  parameter int CW     = 16,
  parameter int N_HPER = 20,
  parameter int TMO    = 65535
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hs_rise_i,
  output logic [CW-1:0] rate_o,
  output logic          rate_vld_o,
  output logic          abort_o
);
  localparam int PW = $clog2(N_HPER + 1);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [PW-1:0] PER_LAST = PW'(N_HPER - 1);
  localparam logic [TW-1:0] GAP_LAST = TW'(TMO - 1);

  logic          armed_q;
  logic [CW-1:0] acc_q, acc_inc, rate_q;
  logic [PW-1:0] per_q;
  logic [TW-1:0] gap_q;
  logic          vld_q, abort_q;

  // saturate rather than wrap on very slow inputs
  assign acc_inc = (&acc_q) ? acc_q : acc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      acc_q   <= '0;
      per_q   <= '0;
      gap_q   <= '0;
      rate_q  <= '0;
      vld_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      vld_q   <= 1'b0;
      abort_q <= 1'b0;
      if (!armed_q) begin
        if (hs_rise_i) begin
          armed_q <= 1'b1;
          acc_q   <= '0;
          per_q   <= '0;
          gap_q   <= '0;
        end
      end else if (hs_rise_i) begin
        gap_q <= '0;
        if (per_q == PER_LAST) begin
          rate_q <= acc_inc;
          vld_q  <= 1'b1;
          acc_q  <= '0;
          per_q  <= '0;
        end else begin
          acc_q <= acc_inc;
          per_q <= per_q + 1'b1;
        end
      end else if (gap_q == GAP_LAST) begin
        armed_q <= 1'b0;
        abort_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
        acc_q <= acc_inc;
      end
    end
  end

  assign rate_o     = rate_q;
  assign rate_vld_o = vld_q;
  assign abort_o    = abort_q;
endmodule

// File: rtl/fmt_frame_meter.sv
module fmt_frame_meter #(
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hs_rise_i,
  input  logic          vs_rise_i,
  input  logic          fs_lvl_i,
  output logic [LW-1:0] lines_o,
  output logic          il_o,
  output logic          frame_vld_o
);
  logic          have_v_q, fs_prev_q, il_q, vld_q;
  logic [LW-1:0] cnt_q, lines_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_v_q  <= 1'b0;
      fs_prev_q <= 1'b0;
      cnt_q     <= '0;
      lines_q   <= '0;
      il_q      <= 1'b0;
      vld_q     <= 1'b0;
    end else if (clr_i) begin
      have_v_q <= 1'b0;
      cnt_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (vs_rise_i) begin
        cnt_q     <= hs_rise_i ? LW'(1) : '0;
        have_v_q  <= 1'b1;
        fs_prev_q <= fs_lvl_i;
        if (have_v_q) begin
          lines_q <= cnt_q;
          il_q    <= fs_lvl_i ^ fs_prev_q;
          vld_q   <= 1'b1;
        end
      end else if (hs_rise_i && !(&cnt_q)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lines_o     = lines_q;
  assign il_o        = il_q;
  assign frame_vld_o = vld_q;
endmodule

// File: rtl/fmt_judge.sv
module fmt_judge
  import fmt_det_pkg::*;
#(
  parameter int CW = 16,
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] min_i,
  input  logic [CW-1:0] max_i,
  input  logic [LW-1:0] exp_lines_i,
  input  logic          exp_il_i,
  input  logic [CW-1:0] rate_i,
  input  logic          rate_vld_i,
  input  logic          abort_i,
  input  logic [LW-1:0] lines_i,
  input  logic          il_i,
  input  logic          frame_vld_i,
  output logic          match_o
);
  judge_st_e st_q;
  logic      seen_q, in_win, pass;

  assign in_win = (rate_i >= min_i) && (rate_i <= max_i);
  assign pass   = (seen_q || rate_vld_i) && in_win &&
                  (lines_i == exp_lines_i) && (il_i == exp_il_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= J_IDLE;
      seen_q <= 1'b0;
    end else if (abort_i) begin
      st_q   <= J_IDLE;
      seen_q <= 1'b0;
    end else begin
      if (rate_vld_i) seen_q <= 1'b1;
      if (!en_i)                     st_q <= J_IDLE;
      else if (rate_vld_i && !in_win) st_q <= J_IDLE;
      else if (frame_vld_i) begin
        if (!pass)               st_q <= J_IDLE;
        else if (st_q == J_IDLE) st_q <= J_HALF;
        else                     st_q <= J_LOCK;
      end
    end
  end

  assign match_o = (st_q == J_LOCK);
endmodule

// File: rtl/video_fmt_detect.sv
module video_fmt_detect #(
  parameter int CW     = 16,
  parameter int LW     = 11,
  parameter int N_HPER = 20,
  parameter int TMO    = 65535
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          fsync_i,
  input  logic          cfg_en_i,
  input  logic [CW-1:0] cfg_min_i,
  input  logic [CW-1:0] cfg_max_i,
  input  logic [LW-1:0] cfg_lines_i,
  input  logic          cfg_interlaced_i,
  output logic          match_o,
  output logic [CW-1:0] rate_o,
  output logic [LW-1:0] lines_o,
  output logic          interlaced_o
);
  logic [2:0]    lvl, rise;
  logic          rate_vld, abort, frame_vld;

  fmt_sync_edge #(.W(3)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({fsync_i, vsync_i, hsync_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  fmt_hrate_meter #(.CW(CW), .N_HPER(N_HPER), .TMO(TMO)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_rise_i  (rise[0]),
    .rate_o     (rate_o),
    .rate_vld_o (rate_vld),
    .abort_o    (abort)
  );

  fmt_frame_meter #(.LW(LW)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (abort),
    .hs_rise_i   (rise[0]),
    .vs_rise_i   (rise[1]),
    .fs_lvl_i    (lvl[2]),
    .lines_o     (lines_o),
    .il_o        (interlaced_o),
    .frame_vld_o (frame_vld)
  );

  fmt_judge #(.CW(CW), .LW(LW)) u_judge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg_en_i),
    .min_i       (cfg_min_i),
    .max_i       (cfg_max_i),
    .exp_lines_i (cfg_lines_i),
    .exp_il_i    (cfg_interlaced_i),
    .rate_i      (rate_o),
    .rate_vld_i  (rate_vld),
    .abort_i     (abort),
    .lines_i     (lines_o),
    .il_i        (interlaced_o),
    .frame_vld_i (frame_vld),
    .match_o     (match_o)
  );
endmodule

// File: rtl/video_fmt_detect_chk.sv
module video_fmt_detect_chk #(
  parameter int CW = 16,
  parameter int LW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_en_i,
  input logic [CW-1:0] cfg_min_i,
  input logic [CW-1:0] cfg_max_i,
  input logic [LW-1:0] cfg_lines_i,
  input logic          cfg_interlaced_i,
  input logic          match_o,
  input logic [CW-1:0] rate_o,
  input logic [LW-1:0] lines_o,
  input logic          interlaced_o,
  input logic          frame_vld,
  input logic          abort
);
  p_off_no_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> !match_o);

  p_abort_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !match_o);

  p_rise_on_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(frame_vld));

  p_rise_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> ($past(rate_o) >= cfg_min_i && $past(rate_o) <= cfg_max_i));

  p_rise_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> ($past(lines_o) == cfg_lines_i &&
                        $past(interlaced_o) == cfg_interlaced_i));

  p_bad_frame_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && lines_o != cfg_lines_i) |=> !match_o);
endmodule

bind video_fmt_detect video_fmt_detect_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_en_i         (cfg_en_i),
  .cfg_min_i        (cfg_min_i),
  .cfg_max_i        (cfg_max_i),
  .cfg_lines_i      (cfg_lines_i),
  .cfg_interlaced_i (cfg_interlaced_i),
  .match_o          (match_o),
  .rate_o           (rate_o),
  .lines_o          (lines_o),
  .interlaced_o     (interlaced_o),
  .frame_vld        (frame_vld),
  .abort            (abort)
);

// File: tb/video_fmt_detect_tb_top.sv
module video_fmt_detect_tb_top;
  localparam int CW = 16, LW = 8, NH = 4, TMO = 64;
  localparam int WMIN = 40, WMAX = 44, XLINES = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0, fsync_i = 1'b0;
  logic cfg_en_i = 1'b0, cfg_interlaced_i = 1'b0;
  logic [CW-1:0] cfg_min_i = '0, cfg_max_i = '0;
  logic [LW-1:0] cfg_lines_i = '0;
  logic match_o, interlaced_o;
  logic [CW-1:0] rate_o;
  logic [LW-1:0] lines_o;

  int n_cmp = 0, n_bad = 0;
  logic fld = 1'b0;

  always #5 clk_i = ~clk_i;

  video_fmt_detect #(.CW(CW), .LW(LW), .N_HPER(NH), .TMO(TMO)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .fsync_i(fsync_i), .cfg_en_i(cfg_en_i), .cfg_min_i(cfg_min_i),
    .cfg_max_i(cfg_max_i), .cfg_lines_i(cfg_lines_i),
    .cfg_interlaced_i(cfg_interlaced_i), .match_o(match_o), .rate_o(rate_o),
    .lines_o(lines_o), .interlaced_o(interlaced_o)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit en, bit cil);
    @(negedge clk_i);
    rst_ni = 1'b0;
    hsync_i = 1'b0; vsync_i = 1'b0; fsync_i = 1'b0; fld = 1'b0;
    cfg_en_i = en; cfg_interlaced_i = cil;
    cfg_min_i = CW'(WMIN); cfg_max_i = CW'(WMAX); cfg_lines_i = LW'(XLINES);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // vsync sits in cycle 2 of the first line, never on an hsync edge
  task automatic frame(int l, int p, bit il);
    if (il) fld = ~fld;
    fsync_i = fld;
    for (int ln = 0; ln < l; ln++) begin
      for (int c = 0; c < p; c++) begin
        hsync_i = (c == 0);
        vsync_i = (ln == 0 && c == 2);
        @(negedge clk_i);
      end
    end
  endtask

  task automatic close_frame();
    vsync_i = 1'b1;
    @(negedge clk_i);
    vsync_i = 1'b0;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset(1'b1, 1'b1);
    chk("R10 match", int'(match_o), 0);
    chk("R10 rate", int'(rate_o), 0);
    chk("R10 lines", int'(lines_o), 0);
    chk("R10 interlaced", int'(interlaced_o), 0);

    for (int p = 9; p <= 12; p++)
      for (int l = 5; l <= 6; l++)
        for (int il = 0; il < 2; il++)
          for (int cil = 0; cil < 2; cil++)
            for (int en = 0; en < 2; en++) begin
              bit exp_m;
              do_reset(en[0], cil[0]);
              frame(l, p, il[0]);
              frame(l, p, il[0]);
              chk("R6 single evaluation", int'(match_o), 0);
              frame(l, p, il[0]);
              frame(l, p, il[0]);
              exp_m = (en != 0) && (NH * p >= WMIN) && (NH * p <= WMAX) &&
                      (l == XLINES) && (il == cil);
              chk("R2 R5 R8 match", int'(match_o), int'(exp_m));
              chk("R1 rate", int'(rate_o), NH * p);
              chk("R3 lines", int'(lines_o), l);
              chk("R4 interlaced", int'(interlaced_o), il);
            end

    // R7: one short frame after lock
    do_reset(1'b1, 1'b1);
    repeat (4) frame(XLINES, 10, 1'b1);
    chk("R7 locked first", int'(match_o), 1);
    frame(XLINES - 1, 10, 1'b1);
    close_frame();
    chk("R7 cleared by bad frame", int'(match_o), 0);

    // R8: enable dropped while locked
    do_reset(1'b1, 1'b0);
    repeat (4) frame(XLINES, 11, 1'b0);
    chk("R8 locked first", int'(match_o), 1);
    cfg_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R8 disabled", int'(match_o), 0);

    // R9: hsync stops
    do_reset(1'b1, 1'b1);
    repeat (4) frame(XLINES, 10, 1'b1);
    chk("R9 locked first", int'(match_o), 1);
    repeat (40) @(negedge clk_i);
    chk("R9 short gap keeps match", int'(match_o), 1);
    repeat (40) @(negedge clk_i);
    chk("R9 timeout clears", int'(match_o), 0);

    summary();
    $finish;
  end
endmodule